// File: doc/BRIEF.md
# Power-Down and Wake-Up Controller

This block sits beside a small microcontroller core and holds two byte-wide control registers on a simple synchronous bus. The power register carries a power-down request and two plain storage bits that drive the serial-port test loopback and the serial pin selection. The interrupt register carries a wake-routing bit, a keypad interrupt enable and a keypad interrupt flag.

When firmware sets the power-down bit, a counter runs for a fixed number of core clocks. When it expires, the enables for the high-speed oscillator and the PLL are dropped together. This gives firmware time to stop the core after the write. Clearing the bit before the count expires aborts the sequence, so the enables never drop.

With routing off, the keypad interrupt goes to line 5, the smart-card interrupt goes to line 4 and the user pins go to line 0. With routing on, lines 4 and 5 are silenced and any of these sources starts a long settling counter. When that counter expires, line 0 is raised, the power-down bit is cleared and the analog enables return. Reading the interrupt register clears the routing bit, so firmware must set routing again before each power-down.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset both registers read 0x00, `osc_en` and `pll_en` are 1, and with all interrupt inputs low all three interrupt outputs are 0.
- R2: The interrupt register sits at 0xFF94 with the routing bit at bit 7, the keypad enable at bit 1 and the keypad flag at bit 0. The power register sits at 0xFFF1 with power-down at bit 7, loopback at bit 1 and pin select at bit 0. Other bits and unmapped addresses read 0, and read data is valid in the same cycle as the read request.
- R3: The loopback and pin-select bits are read/write storage that drive `uart_loop` and `pin_sel` unchanged from the clock edge of the write.
- R4: A `kp_evt` pulse sets the keypad flag whether or not the enable is set. Writing 1 to bit 0 of the interrupt register clears the flag. An event in the same cycle as the clear wins.
- R5: With routing off, `irq5` equals flag AND enable, `irq4` follows `sc_irq` and `irq0` is the OR of `usr_irq`, all without a register stage.
- R6: A read of the interrupt register clears the routing bit at the clock edge that ends the read. The value returned still shows the old bit.
- R7: With routing on, `irq4` and `irq5` stay 0. The first clock edge that samples any source high (enabled keypad interrupt, `sc_irq` or any user pin) starts a count, and `irq0` rises exactly WAKE_DELAY (512) edges later. It stays high until routing is cleared, and clearing routing during the count aborts it.
- R8: `osc_en` and `pll_en` fall together exactly PD_DELAY (32) clock edges after the edge that writes power-down to 1.
- R9: Writing power-down to 0 before the count expires aborts it, so the enables never fall. Writing it to 0 after expiry raises the enables from that write edge.
- R10: When the routed wake interrupt fires, `osc_en` and `pll_en` are 1 in the same cycle `irq0` rises, and the power-down bit reads 0 from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, kept alive during power-down |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the request cycle |
| kp_evt | input | 1 | Keypad event pulse |
| sc_irq | input | 1 | Smart-card interrupt request |
| usr_irq | input | 8 | User pin interrupt requests |
| irq0 | output | 1 | Interrupt line 0 |
| irq4 | output | 1 | Interrupt line 4 |
| irq5 | output | 1 | Interrupt line 5 |
| osc_en | output | 1 | High-speed oscillator enable |
| pll_en | output | 1 | PLL enable |
| uart_loop | output | 1 | Serial loopback test mode |
| pin_sel | output | 1 | Serial pin selection |

## Verification
On every cycle the assertions check the following:
- Lines 4 and 5 stay silent while routing is on.
- Line 5 is never raised without the enable.
- A read of the interrupt register always leaves routing cleared.
- A fired wake always clears power-down.
- An enable fall comes only after exactly PD_DELAY cycles of an uninterrupted request.
- The wake never fires before routing has been held for WAKE_DELAY cycles.

Only the bench scenarios can show the rest:
- The exact rise cycle of `irq0` after the 512-edge count.
- Abort of the power-down count by a cancel write.
- The write-1-to-clear behaviour of the flag.
- The register map read back through the bus.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

  localparam int ICTL_ROUTE_B = 7;
  localparam int ICTL_KPEN_B  = 1;
  localparam int ICTL_KPFLG_B = 0;

  localparam int MCTL_PD_B    = 7;
  localparam int MCTL_LOOP_B  = 1;
  localparam int MCTL_PSEL_B  = 0;

  typedef struct packed {
    logic route;
    logic kp_en;
    logic kp_flag;
  } ictl_t;

  typedef struct packed {
    logic pd;
    logic loopbk;
    logic psel;
  } mctl_t;

endpackage

// File: rtl/pwr_regs.sv
module pwr_regs
  import pwr_wake_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] ICTL_ADDR = 16'hFF94,
  parameter logic [15:0] MCTL_ADDR = 16'hFFF1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kp_evt,
  input  logic              wake_fire,
  output ictl_t             ictl_q,
  output mctl_t             mctl_q
);

  logic  hit_ictl, hit_mctl;
  logic  wr_ictl, rd_ictl, wr_mctl;
  ictl_t ictl_d;
  mctl_t mctl_d;

  assign hit_ictl = (bus_addr == ADDR_W'(ICTL_ADDR));
  assign hit_mctl = (bus_addr == ADDR_W'(MCTL_ADDR));
  assign wr_ictl  = bus_sel &  bus_wr & hit_ictl;
  assign rd_ictl  = bus_sel & ~bus_wr & hit_ictl;
  assign wr_mctl  = bus_sel &  bus_wr & hit_mctl;

  // next state: interrupt control
  always_comb begin
    ictl_d = ictl_q;
    if (wr_ictl) begin
      ictl_d.route = bus_wdata[ICTL_ROUTE_B];
      ictl_d.kp_en = bus_wdata[ICTL_KPEN_B];
      if (bus_wdata[ICTL_KPFLG_B]) ictl_d.kp_flag = 1'b0;
    end
    if (rd_ictl) ictl_d.route = 1'b0;
    if (kp_evt) ictl_d.kp_flag = 1'b1;
  end

  // next state: power control
  always_comb begin
    mctl_d = mctl_q;
    if (wr_mctl) begin
      mctl_d.pd     = bus_wdata[MCTL_PD_B];
      mctl_d.loopbk = bus_wdata[MCTL_LOOP_B];
      mctl_d.psel   = bus_wdata[MCTL_PSEL_B];
    end
    if (wake_fire) mctl_d.pd = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ictl_q <= '0;
      mctl_q <= '0;
    end else begin
      ictl_q <= ictl_d;
      mctl_q <= mctl_d;
    end
  end

  // combinational read path
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (hit_ictl) begin
        bus_rdata[ICTL_ROUTE_B] = ictl_q.route;
        bus_rdata[ICTL_KPEN_B]  = ictl_q.kp_en;
        bus_rdata[ICTL_KPFLG_B] = ictl_q.kp_flag;
      end else if (hit_mctl) begin
        bus_rdata[MCTL_PD_B]    = mctl_q.pd;
        bus_rdata[MCTL_LOOP_B]  = mctl_q.loopbk;
        bus_rdata[MCTL_PSEL_B]  = mctl_q.psel;
      end
    end
  end

endmodule

// File: rtl/pwr_down_seq.sv
module pwr_down_seq #(
  parameter int PD_DELAY = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  output logic ana_off
);

  localparam int CW = $clog2(PD_DELAY + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          off_q, off_d;

  always_comb begin
    cnt_d = cnt_q;
    off_d = off_q;
    if (!pd_req) begin
      cnt_d = '0;
      off_d = 1'b0;
    end else if (!off_q) begin
      if (cnt_q == CW'(PD_DELAY - 1)) off_d = 1'b1;
      else                            cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      off_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      off_q <= off_d;
    end
  end

  assign ana_off = off_q;

endmodule

// File: rtl/wake_route.sv
module wake_route #(
  parameter int WAKE_DELAY = 512,
  parameter int USR_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             route,
  input  logic             kp_irq,
  input  logic             sc_irq,
  input  logic [USR_W-1:0] usr_irq,
  output logic             irq0,
  output logic             irq4,
  output logic             irq5,
  output logic             fire
);

  localparam int CW = $clog2(WAKE_DELAY + 1);

  logic          usr_any, src_any;
  logic          armed_q, armed_d;
  logic          fire_q,  fire_d;
  logic [CW-1:0] cnt_q,   cnt_d;

  assign usr_any = |usr_irq;
  assign src_any = kp_irq | sc_irq | usr_any;

  always_comb begin
    armed_d = armed_q;
    fire_d  = fire_q;
    cnt_d   = cnt_q;
    if (!route) begin
      armed_d = 1'b0;
      fire_d  = 1'b0;
      cnt_d   = '0;
    end else if (!fire_q) begin
      if (armed_q) begin
        if (cnt_q == CW'(WAKE_DELAY)) begin
          fire_d  = 1'b1;
          armed_d = 1'b0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end else if (src_any) begin
        armed_d = 1'b1;
        cnt_d   = CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      fire_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      fire_q  <= fire_d;
      cnt_q   <= cnt_d;
    end
  end

  assign irq0 = route ? fire_q : usr_any;
  assign irq4 = route ? 1'b0   : sc_irq;
  assign irq5 = route ? 1'b0   : kp_irq;
  assign fire = fire_q;

endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 8,
  parameter int          USR_W      = 8,
  parameter int          PD_DELAY   = 32,
  parameter int          WAKE_DELAY = 512,
  parameter logic [15:0] ICTL_ADDR  = 16'hFF94,
  parameter logic [15:0] MCTL_ADDR  = 16'hFFF1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kp_evt,
  input  logic              sc_irq,
  input  logic [USR_W-1:0]  usr_irq,
  output logic              irq0,
  output logic              irq4,
  output logic              irq5,
  output logic              osc_en,
  output logic              pll_en,
  output logic              uart_loop,
  output logic              pin_sel
);

  ictl_t ictl_q;
  mctl_t mctl_q;
  logic  wake_fire;
  logic  ana_off;
  logic  route_q, pd_q, kp_en_q, kp_irq;
  logic  ana_on;

  pwr_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ICTL_ADDR(ICTL_ADDR), .MCTL_ADDR(MCTL_ADDR)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kp_evt(kp_evt), .wake_fire(wake_fire),
    .ictl_q(ictl_q), .mctl_q(mctl_q)
  );

  pwr_down_seq #(.PD_DELAY(PD_DELAY)) pdseq_i (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_q), .ana_off(ana_off)
  );

  wake_route #(.WAKE_DELAY(WAKE_DELAY), .USR_W(USR_W)) route_i (
    .clk(clk), .rst_n(rst_n), .route(route_q),
    .kp_irq(kp_irq), .sc_irq(sc_irq), .usr_irq(usr_irq),
    .irq0(irq0), .irq4(irq4), .irq5(irq5), .fire(wake_fire)
  );

  assign route_q   = ictl_q.route;
  assign kp_en_q   = ictl_q.kp_en;
  assign pd_q      = mctl_q.pd;
  assign kp_irq    = ictl_q.kp_flag & ictl_q.kp_en;

  // the power-down override holds only while the request bit stands
  assign ana_on    = ~(ana_off & pd_q) | wake_fire;
  assign osc_en    = ana_on;
  assign pll_en    = ana_on;
  assign uart_loop = mctl_q.loopbk;
  assign pin_sel   = mctl_q.psel;

endmodule

// File: rtl/pwr_wake_chk.sv
module pwr_wake_chk #(
  parameter int          ADDR_W     = 16,
  parameter int          PD_DELAY   = 32,
  parameter int          WAKE_DELAY = 512,
  parameter logic [15:0] ICTL_ADDR  = 16'hFF94
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              route_q,
  input logic              pd_q,
  input logic              kp_en_q,
  input logic              wake_fire,
  input logic              osc_en,
  input logic              irq4,
  input logic              irq5
);

  logic [15:0] pd_run, rt_run;
  logic        rd_ictl;

  assign rd_ictl = bus_sel && !bus_wr && (bus_addr == ADDR_W'(ICTL_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_run <= '0;
      rt_run <= '0;
    end else begin
      if (!pd_q)              pd_run <= '0;
      else if (pd_run != '1)  pd_run <= pd_run + 16'd1;
      if (!route_q)           rt_run <= '0;
      else if (rt_run != '1)  rt_run <= rt_run + 16'd1;
    end
  end

  AST_PD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> (pd_run == 16'(PD_DELAY))); // R8

  AST_ROUTE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    route_q |-> (!irq4 && !irq5)); // R7

  AST_WAKE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_fire) |-> (rt_run >= 16'(WAKE_DELAY))); // R7

  AST_KP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq5 |-> kp_en_q); // R5

  AST_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ictl |=> !route_q); // R6

  AST_WAKE_PD: assert property (@(posedge clk) disable iff (!rst_n)
    wake_fire |=> !pd_q); // R10

endmodule

bind pwr_wake_ctrl pwr_wake_chk #(
  .ADDR_W(ADDR_W), .PD_DELAY(PD_DELAY),
  .WAKE_DELAY(WAKE_DELAY), .ICTL_ADDR(ICTL_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .route_q(route_q), .pd_q(pd_q), .kp_en_q(kp_en_q),
  .wake_fire(wake_fire), .osc_en(osc_en), .irq4(irq4), .irq5(irq5)
);

// File: tb/pwr_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_wake_ctrl_tb_top;

  localparam logic [15:0] A_ICTL = 16'hFF94;
  localparam logic [15:0] A_MCTL = 16'hFFF1;

  // {is_write, address, data or expected read value}
  localparam int NV = 10;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 16'hFFF1, 8'h03},
    {1'b0, 16'hFFF1, 8'h03},
    {1'b1, 16'hFFF1, 8'h02},
    {1'b0, 16'hFFF1, 8'h02},
    {1'b1, 16'hFF94, 8'h02},
    {1'b0, 16'hFF94, 8'h02},
    {1'b0, 16'h1234, 8'h00},
    {1'b1, 16'hFF94, 8'h82},
    {1'b0, 16'hFF94, 8'h82},
    {1'b0, 16'hFF94, 8'h02}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr, kp_evt, sc_irq;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata, usr_irq;
  logic        irq0, irq4, irq5, osc_en, pll_en, uart_loop, pin_sel;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  pwr_wake_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kp_evt(kp_evt), .sc_irq(sc_irq), .usr_irq(usr_irq),
    .irq0(irq0), .irq4(irq4), .irq5(irq5), .osc_en(osc_en),
    .pll_en(pll_en), .uart_loop(uart_loop), .pin_sel(pin_sel)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; kp_evt = 1'b0; sc_irq = 1'b0; usr_irq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 enables", {6'd0, osc_en, pll_en}, 8'h03);
    check("R1 irqs", {5'd0, irq0, irq4, irq5}, 8'h00);
    bus_read(A_ICTL, rv); check("R1 ictl", rv, 8'h00);
    bus_read(A_MCTL, rv); check("R1 mctl", rv, 8'h00);

    // table walk: R2 register map, R3 storage bits, R6 read clear
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) begin
        bus_write(VEC[i][23:8], VEC[i][7:0]);
        if (VEC[i][23:8] == A_MCTL)
          check("R3 ports", {6'd0, uart_loop, pin_sel}, {6'd0, VEC[i][1:0]});
      end else begin
        bus_read(VEC[i][23:8], rv);
        check("R2/R6 read", rv, VEC[i][7:0]);
      end
    end

    // R5 direct paths with routing off
    @(negedge clk); sc_irq = 1'b1; usr_irq = 8'h10;
    #1 check("R5 sc/usr", {6'd0, irq4, irq0}, 8'h03);
    @(negedge clk); sc_irq = 1'b0; usr_irq = '0;
    #1 check("R5 idle", {5'd0, irq0, irq4, irq5}, 8'h00);

    // R4/R5 keypad flag with enable set
    @(negedge clk); kp_evt = 1'b1;
    @(negedge clk); kp_evt = 1'b0;
    check("R5 irq5", {7'd0, irq5}, 8'h01);
    bus_read(A_ICTL, rv); check("R4 flag set", rv, 8'h03);
    bus_write(A_ICTL, 8'h03);
    check("R4 w1c irq5", {7'd0, irq5}, 8'h00);
    bus_read(A_ICTL, rv); check("R4 cleared", rv, 8'h02);

    // R4 flag sets without enable, irq5 stays low
    bus_write(A_ICTL, 8'h00);
    @(negedge clk); kp_evt = 1'b1;
    @(negedge clk); kp_evt = 1'b0;
    check("R4 no enable irq5", {7'd0, irq5}, 8'h00);
    bus_read(A_ICTL, rv); check("R4 flag without enable", rv, 8'h01);
    bus_write(A_ICTL, 8'h01);

    // R8 exact power-down timing
    bus_write(A_MCTL, 8'h80);
    for (int k = 1; k < 32; k++) begin
      @(negedge clk);
      if (osc_en !== 1'b1) check("R8 early drop", {7'd0, osc_en}, 8'h01);
    end
    n_chk++;
    @(negedge clk);
    check("R8 drop at 32", {6'd0, osc_en, pll_en}, 8'h00);

    // R9 clear after expiry restores enables
    bus_write(A_MCTL, 8'h00);
    check("R9 restore", {6'd0, osc_en, pll_en}, 8'h03);

    // R9 cancel before expiry
    bus_write(A_MCTL, 8'h80);
    repeat (9) @(negedge clk);
    bus_write(A_MCTL, 8'h00);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (osc_en !== 1'b1 || pll_en !== 1'b1)
        check("R9 cancel held", {6'd0, osc_en, pll_en}, 8'h03);
    end
    n_chk++;

    // R7/R10 routed wake
    bus_write(A_ICTL, 8'h80);
    bus_write(A_MCTL, 8'h80);
    repeat (40) @(negedge clk);
    check("R8 off before wake", {7'd0, osc_en}, 8'h00);
    @(negedge clk); sc_irq = 1'b1;
    #1 check("R7 irq4 masked", {7'd0, irq4}, 8'h00);
    @(negedge clk); sc_irq = 1'b0;
    repeat (511) @(negedge clk);
    check("R7 not yet", {6'd0, irq0, osc_en}, 8'h00);
    @(negedge clk);
    check("R7 irq0 at 512", {7'd0, irq0}, 8'h01);
    check("R10 enables back", {6'd0, osc_en, pll_en}, 8'h03);
    bus_read(A_MCTL, rv); check("R10 pd cleared", rv, 8'h00);
    bus_read(A_ICTL, rv); check("R6 read shows route", rv, 8'h80);
    check("R7 irq0 released", {7'd0, irq0}, 8'h00);

    finish_run();
  end

endmodule